// File: doc/BRIEF.md
# Trace Output Port with Backpressure

This block sits between a trace packet builder and the external trace pins. Packed trace bytes are pushed into a 16-entry byte FIFO. Each cycle the port may advance: it then forms one beat on a data bus and a single control line, taking as many bytes from the FIFO as the selected port width holds. Idle, disabled and trigger conditions are signalled in-band. The control line is high for all three, and data bit 0 tells a trigger (bit 0 low) apart from idle or disabled (bit 0 high). A valid strobe and a trigger strobe come out alongside, so a capture device can use the valid strobe directly as a clock enable.

A ready input from the capture side freezes the port. While it is low nothing leaves the FIFO and every output keeps its value. The port width is requested by a code and limited by a configured maximum code. The narrowest width sends each byte as two nibbles. A standby request asks the port to drain. An active-low readiness output goes low once nothing is left to send, so the surrounding logic knows it may stop the clock.

Top module: `trc_port`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are: `trc_ctl`=1, `trc_data`=0x00000001, `trc_valid`=0, `trc_trigger`=0, `port_en`=0, `overflow`=0.
- R2: A data beat drives `trc_ctl`=0 and `trc_valid`=1. The oldest FIFO byte goes on `trc_data[7:0]`, the next on `[15:8]`, and so on up the lanes.
- R3: An advancing cycle drives the idle encoding (`trc_ctl`=1, `trc_data`=0x00000001, `trc_valid`=0) when tracing is enabled but there is no trigger and the FIFO is empty. It drives the same encoding when `trace_en` is low and no nibble is half sent, and it then takes no byte from the FIFO. `port_en` equals `trace_en` delayed by one clock.
- R4: A pulse on `trig_req` is held pending. The next advancing beat boundary with tracing enabled emits `trc_ctl`=1 with `trc_data`=0 and `trc_trigger`=1 for one beat. This beat comes ahead of any queued data, and no byte is taken in it. `trc_trigger` is high exactly when `trc_ctl` is high and `trc_data[0]` is low.
- R5: `trc_valid` always equals (not `trc_ctl`) or (not `trc_data[0]`).
- R6: In a cycle where `out_ready` is low, no byte leaves the FIFO, and `trc_ctl`, `trc_data`, `trc_valid` and `trc_trigger` hold their values into the next cycle.
- R7: The size codes are 0 = 4-bit, 1 = 8-bit, 2 = 16-bit, 3 = 24-bit and 4 = 32-bit. Any code above 4 counts as 4. The effective size is the smaller of the requested code and the maximum code.
- R8: At size code 0, one byte is sent over two advancing beats. The first carries the low nibble on `trc_data[3:0]` and the second the high nibble, with all other data bits 0 in both. The second beat is always sent next, even if tracing was disabled or a trigger became pending in between.
- R9: When the FIFO holds fewer bytes than the port width, the bytes it holds are sent and the unused lanes carry 0x00. `trc_valid` still pulses.
- R10: The FIFO stores 16 bytes. A push is accepted only if fewer than 16 bytes were stored before that clock, even if a pop happens in the same cycle. A refused push sets `overflow`, which stays set until reset.
- R11: `standby_ready_n` is low exactly when `standby_req` is high, the FIFO is empty and no nibble is half sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_vld | input | 1 | Push a byte into the FIFO |
| push_byte | input | 8 | Byte to push |
| trig_req | input | 1 | Request a trigger beat |
| trace_en | input | 1 | Tracing enabled |
| size_req | input | 4 | Requested port size code |
| size_max | input | 4 | Largest size code allowed |
| out_ready | input | 1 | Capture side ready; low freezes the port |
| standby_req | input | 1 | Standby pending, drain requested |
| trc_ctl | output | 1 | Trace control line |
| trc_data | output | 32 | Trace data bus |
| trc_valid | output | 1 | One strobe per transferred beat |
| trc_trigger | output | 1 | Trigger beat strobe |
| port_en | output | 1 | Port enabled |
| standby_ready_n | output | 1 | Low when drained and safe for standby |
| overflow | output | 1 | Sticky FIFO overflow flag |

## Verification
The bench aims at the points where beats and FIFO updates meet. It pushes into a full FIFO in the same cycle as a pop: a design that judged fullness after the pop would accept a byte it should drop, and the byte stream would shift. It raises triggers, disables tracing and drops ready in the middle of a nibble pair. A design that let these cut into the pair would lose the high nibble. It also stalls right as a partial beat forms, and a design that drained while frozen would lose padded bytes. Requested sizes above the maximum and codes above 4 check the clamp, since a wrong clamp changes the byte count per beat.

// File: rtl/trc_port_pkg.sv
package trc_port_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam logic [7:0]  PAD_BYTE = 8'h00;

  typedef enum logic [2:0] {
    SZ_NIB = 3'd0,
    SZ_B1  = 3'd1,
    SZ_B2  = 3'd2,
    SZ_B3  = 3'd3,
    SZ_B4  = 3'd4
  } trc_size_e;

  // Codes beyond the widest port map onto the widest port.
  function automatic logic [2:0] clamp_code(input logic [3:0] code);
    return (code > 4'd4) ? 3'd4 : code[2:0];
  endfunction

endpackage

// File: rtl/trc_rst_sync.sv
module trc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/trc_size_sel.sv
module trc_size_sel
  import trc_port_pkg::*;
(
  input  logic [3:0] size_req,
  input  logic [3:0] size_max,
  output trc_size_e  size_eff
);
  logic [2:0] req_c;
  logic [2:0] max_c;

  always_comb begin
    req_c    = clamp_code(size_req);
    max_c    = clamp_code(size_max);
    size_eff = trc_size_e'((req_c < max_c) ? req_c : max_c);
  end
endmodule

// File: rtl/trc_fifo.sv
module trc_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PEEK  = 4,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned PW = $clog2(PEEK + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push_vld,
  input  logic [7:0]           push_byte,
  input  logic [PW-1:0]        pop_cnt,
  output logic [PEEK-1:0][7:0] peek,
  output logic [CW-1:0]        count,
  output logic                 overflow
);
  // DEPTH is a power of two so the pointers wrap by themselves.
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          ovf_q, ovf_n;
  logic          push_ok;

  always_comb begin
    push_ok = push_vld && (cnt_q < CW'(DEPTH));
    wr_n    = wr_q + AW'(push_ok);
    rd_n    = rd_q + AW'(pop_cnt);
    cnt_n   = cnt_q + CW'(push_ok) - CW'(pop_cnt);
    ovf_n   = ovf_q | (push_vld & ~push_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= push_byte;
  end

  for (genvar gi = 0; gi < PEEK; gi++) begin : g_peek
    assign peek[gi] = mem[rd_q + AW'(gi)];
  end

  assign count    = cnt_q;
  assign overflow = ovf_q;

  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_cnt) <= cnt_q);
  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
endmodule

// File: rtl/trc_beat.sv
module trc_beat
  import trc_port_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned CW    = 5,
  localparam int unsigned PW = $clog2(LANES + 1),
  localparam int unsigned DW = LANES * BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv,
  input  logic                  trace_en,
  input  trc_size_e             size,
  input  logic                  trig_req,
  input  logic [CW-1:0]         count,
  input  logic [LANES-1:0][7:0] peek,
  output logic [PW-1:0]         pop_cnt,
  output logic                  ctl,
  output logic [DW-1:0]         data,
  output logic                  valid,
  output logic                  trig,
  output logic                  nib_busy
);
  localparam logic [DW-1:0] IDLE_WORD = DW'(1);

  logic          ctl_q, ctl_n, valid_q, valid_n, trig_q, trig_n;
  logic [DW-1:0] data_q, data_n;
  logic          phase_q, phase_n, pend_q, pend_n;
  logic [3:0]    hin_q, hin_n;
  logic [CW-1:0] want, take;
  logic          emit;

  always_comb begin
    want    = (size == SZ_NIB) ? CW'(1) : CW'(size);
    take    = (count < want) ? count : want;
    ctl_n   = ctl_q;
    data_n  = data_q;
    valid_n = valid_q;
    trig_n  = trig_q;
    phase_n = phase_q;
    hin_n   = hin_q;
    pop_cnt = '0;
    emit    = 1'b0;
    if (adv) begin
      if (phase_q) begin
        ctl_n       = 1'b0;
        data_n      = '0;
        data_n[3:0] = hin_q;
        valid_n     = 1'b1;
        trig_n      = 1'b0;
        phase_n     = 1'b0;
      end else if (!trace_en || (!pend_q && count == '0)) begin
        ctl_n   = 1'b1;
        data_n  = IDLE_WORD;
        valid_n = 1'b0;
        trig_n  = 1'b0;
      end else if (pend_q) begin
        ctl_n   = 1'b1;
        data_n  = '0;
        valid_n = 1'b1;
        trig_n  = 1'b1;
        emit    = 1'b1;
      end else if (size == SZ_NIB) begin
        ctl_n       = 1'b0;
        data_n      = '0;
        data_n[3:0] = peek[0][3:0];
        hin_n       = peek[0][7:4];
        valid_n     = 1'b1;
        trig_n      = 1'b0;
        phase_n     = 1'b1;
        pop_cnt     = PW'(1);
      end else begin
        ctl_n   = 1'b0;
        valid_n = 1'b1;
        trig_n  = 1'b0;
        for (int i = 0; i < LANES; i++) begin
          data_n[i*BYTE_W +: BYTE_W] = (CW'(i) < take) ? peek[i] : PAD_BYTE;
        end
        pop_cnt = PW'(take);
      end
    end
    pend_n = (pend_q & ~emit) | trig_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= 1'b1;
      data_q  <= IDLE_WORD;
      valid_q <= 1'b0;
      trig_q  <= 1'b0;
      phase_q <= 1'b0;
      hin_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      ctl_q   <= ctl_n;
      data_q  <= data_n;
      valid_q <= valid_n;
      trig_q  <= trig_n;
      phase_q <= phase_n;
      hin_q   <= hin_n;
      pend_q  <= pend_n;
    end
  end

  assign ctl      = ctl_q;
  assign data     = data_q;
  assign valid    = valid_q;
  assign trig     = trig_q;
  assign nib_busy = phase_q;

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(ctl_q) && $stable(data_q) && $stable(valid_q) && $stable(trig_q)));
  assert_valid_enc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q == (!ctl_q || !data_q[0]));
  assert_trig_enc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q == (ctl_q && !data_q[0]));
  assert_nib_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q && adv) |=> (!ctl_q && valid_q && !phase_q));
  assert_no_drain_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!trace_en && !phase_q) |-> (pop_cnt == '0));
endmodule

// File: rtl/trc_port.sv
module trc_port
  import trc_port_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned DW = LANES * BYTE_W,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned PW = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_vld,
  input  logic [7:0]    push_byte,
  input  logic          trig_req,
  input  logic          trace_en,
  input  logic [3:0]    size_req,
  input  logic [3:0]    size_max,
  input  logic          out_ready,
  input  logic          standby_req,
  output logic          trc_ctl,
  output logic [DW-1:0] trc_data,
  output logic          trc_valid,
  output logic          trc_trigger,
  output logic          port_en,
  output logic          standby_ready_n,
  output logic          overflow
);
  logic                  rst_i_n;
  trc_size_e             size_eff;
  logic [PW-1:0]         pop_cnt;
  logic [LANES-1:0][7:0] peek;
  logic [CW-1:0]         fifo_cnt;
  logic                  nib_busy;
  logic                  port_en_q;

  trc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  trc_size_sel u_size (
    .size_req (size_req),
    .size_max (size_max),
    .size_eff (size_eff)
  );

  trc_fifo #(.DEPTH(DEPTH), .PEEK(LANES)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .push_vld  (push_vld),
    .push_byte (push_byte),
    .pop_cnt   (pop_cnt),
    .peek      (peek),
    .count     (fifo_cnt),
    .overflow  (overflow)
  );

  trc_beat #(.LANES(LANES), .CW(CW)) u_beat (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .adv      (out_ready),
    .trace_en (trace_en),
    .size     (size_eff),
    .trig_req (trig_req),
    .count    (fifo_cnt),
    .peek     (peek),
    .pop_cnt  (pop_cnt),
    .ctl      (trc_ctl),
    .data     (trc_data),
    .valid    (trc_valid),
    .trig     (trc_trigger),
    .nib_busy (nib_busy)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) port_en_q <= 1'b0;
    else          port_en_q <= trace_en;
  end

  assign port_en         = port_en_q;
  assign standby_ready_n = ~(standby_req & (fifo_cnt == '0) & ~nib_busy);

  assert_standby_empty_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !standby_ready_n |-> (fifo_cnt == '0 && !nib_busy));
  assert_clamp_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (3'(size_eff) <= clamp_code(size_max)) && (3'(size_eff) <= clamp_code(size_req)));
  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    !out_ready |-> (pop_cnt == '0));
endmodule

// File: tb/trc_port_tb_top.sv
`timescale 1ns/1ps
module trc_port_tb_top;
  localparam time CLK_P = 8ns;

  logic        clk = 1'b0;
  logic        rst_n, push_vld, trig_req, trace_en, out_ready, standby_req;
  logic [7:0]  push_byte;
  logic [3:0]  size_req, size_max;
  logic        trc_ctl, trc_valid, trc_trigger, port_en, standby_ready_n, overflow;
  logic [31:0] trc_data;

  int    n_chk  = 0;
  int    n_fail = 0;
  string scene  = "R1 reset";

  // reference model state
  logic [7:0]  q[$];
  logic        m_ctl, m_valid, m_trig, m_phase, m_pend, m_pen, m_ovf;
  logic [31:0] m_data;
  logic [3:0]  m_hin;

  always #(CLK_P/2) clk = ~clk;

  trc_port dut_i (
    .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_byte(push_byte),
    .trig_req(trig_req), .trace_en(trace_en), .size_req(size_req), .size_max(size_max),
    .out_ready(out_ready), .standby_req(standby_req), .trc_ctl(trc_ctl), .trc_data(trc_data),
    .trc_valid(trc_valid), .trc_trigger(trc_trigger), .port_en(port_en),
    .standby_ready_n(standby_ready_n), .overflow(overflow)
  );

  function automatic int clampc(input logic [3:0] c);
    return (c > 4) ? 4 : int'(c);
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s / %s: actual=%h expected=%h at %0t", scene, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // behavioural model, one step per clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_ctl = 1; m_data = 32'h1; m_valid = 0; m_trig = 0;
      m_phase = 0; m_pend = 0; m_pen = 0; m_ovf = 0; m_hin = 0;
    end else begin
      int  eff, nb, pre;
      bit  emit, acc;
      logic [7:0] b;
      eff  = (clampc(size_req) < clampc(size_max)) ? clampc(size_req) : clampc(size_max);
      nb   = (eff == 0) ? 1 : eff;
      pre  = q.size();
      acc  = push_vld && (pre < 16);
      emit = 0;
      if (out_ready) begin
        if (m_phase) begin
          m_ctl = 0; m_data = {28'h0, m_hin}; m_valid = 1; m_trig = 0; m_phase = 0;
        end else if (!trace_en || (!m_pend && pre == 0)) begin
          m_ctl = 1; m_data = 32'h1; m_valid = 0; m_trig = 0;
        end else if (m_pend) begin
          m_ctl = 1; m_data = 32'h0; m_valid = 1; m_trig = 1; emit = 1;
        end else if (eff == 0) begin
          b = q.pop_front();
          m_ctl = 0; m_data = {28'h0, b[3:0]}; m_hin = b[7:4]; m_valid = 1; m_trig = 0; m_phase = 1;
        end else begin
          m_data = 32'h0;
          for (int i = 0; i < nb; i++) if (q.size() > 0) m_data[i*8 +: 8] = q.pop_front();
          m_ctl = 0; m_valid = 1; m_trig = 0;
        end
      end
      if (acc) q.push_back(push_byte);
      else if (push_vld) m_ovf = 1;
      m_pend = (m_pend && !emit) || trig_req;
      m_pen  = trace_en;
    end
  end

  // compare every clock, 2 ns after the edge
  always @(posedge clk) begin
    logic exp_sb;
    #2;
    exp_sb = !(standby_req && q.size() == 0 && !m_phase);
    chk(trc_ctl === m_ctl, "R3 ctl", 32'(trc_ctl), 32'(m_ctl));
    chk(trc_data === m_data, "R2 data", trc_data, m_data);
    chk(trc_valid === m_valid, "R5 valid", 32'(trc_valid), 32'(m_valid));
    chk(trc_trigger === m_trig, "R4 trigger", 32'(trc_trigger), 32'(m_trig));
    chk(port_en === m_pen, "R3 port_en", 32'(port_en), 32'(m_pen));
    chk(overflow === m_ovf, "R10 overflow", 32'(overflow), 32'(m_ovf));
    chk(standby_ready_n === exp_sb, "R11 standby_ready_n", 32'(standby_ready_n), 32'(exp_sb));
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      push_vld = 1; push_byte = base + 8'(i); cyc(1);
    end
    push_vld = 0;
  endtask

  initial begin
    rst_n = 0; push_vld = 0; push_byte = 0; trig_req = 0; trace_en = 0;
    size_req = 4'd1; size_max = 4'd4; out_ready = 1; standby_req = 0;
    cyc(3);
    chk(trc_ctl === 1'b1 && trc_data === 32'h1 && !trc_valid && !trc_trigger, "R1 reset outputs",
        {trc_data[30:0], trc_ctl}, 32'h3);
    chk(!port_en && !overflow, "R1 reset flags", 32'({port_en, overflow}), 32'h0);
    rst_n = 1;
    cyc(4);

    scene = "R2 byte order 8-bit"; trace_en = 1; load(6, 8'h10); cyc(4);
    scene = "R7 R9 16-bit odd"; trace_en = 0; size_req = 4'd2; load(7, 8'h20); trace_en = 1; cyc(6);
    scene = "R9 32-bit partial"; trace_en = 0; size_req = 4'd4; load(7, 8'h30); trace_en = 1; cyc(4);
    scene = "R7 clamp to 24-bit"; trace_en = 0; size_max = 4'd3; load(8, 8'h40); trace_en = 1; cyc(5);
    scene = "R7 code above 4"; trace_en = 0; size_req = 4'd9; size_max = 4'd15; load(9, 8'h50); trace_en = 1; cyc(5);
    scene = "R8 nibbles"; trace_en = 0; size_req = 4'd0; load(3, 8'hA5); trace_en = 1; cyc(1);
    trig_req = 1; cyc(1); trig_req = 0; trace_en = 0; cyc(2); trace_en = 1; cyc(8);
    scene = "R4 trigger ahead of data"; size_req = 4'd1; trace_en = 0; load(3, 8'h60);
    trig_req = 1; cyc(1); trig_req = 0; trace_en = 1; cyc(6);
    scene = "R6 stall"; trace_en = 0; size_req = 4'd2; load(5, 8'h70); trace_en = 1;
    out_ready = 0; cyc(3); out_ready = 1; cyc(1); out_ready = 0; cyc(2); out_ready = 1; cyc(4);
    scene = "R6 R8 stall mid nibble"; size_req = 4'd0; trace_en = 0; load(2, 8'h3C); trace_en = 1;
    cyc(1); out_ready = 0; cyc(3); out_ready = 1; cyc(6);
    scene = "R10 overflow"; trace_en = 0; size_req = 4'd1; load(20, 8'h80); cyc(2);
    scene = "R10 push at full with pop"; trace_en = 1; push_vld = 1; push_byte = 8'hEE; cyc(1);
    push_vld = 0; cyc(2);
    scene = "R11 standby drain"; standby_req = 1; cyc(20); standby_req = 0; cyc(2);
    scene = "R3 disabled no drain"; trace_en = 0; load(3, 8'h90); cyc(4); trace_en = 1; cyc(4);

    scene = "mixed R2 R4 R6 R8 R9 R10 R11";
    for (int c = 0; c < 3000; c++) begin
      push_vld    = ($urandom % 3) != 0;
      push_byte   = 8'($urandom);
      out_ready   = ($urandom % 4) != 0;
      trig_req    = ($urandom % 40) == 0;
      trace_en    = ($urandom % 16) != 0;
      standby_req = ($urandom % 8) == 0;
      if (c % 60 == 0) begin
        size_req = 4'($urandom % 7);
        size_max = 4'($urandom % 6);
      end
      cyc(1);
    end
    push_vld = 0; trig_req = 0; out_ready = 1; trace_en = 1; cyc(40);
    summary();
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end
endmodule